// File: doc/BRIEF.md
# FIFO-to-Host Packet Handoff Controller

This controller empties a single-clock FIFO one packet at a time and passes each packet to a host processor. It waits until the FIFO reports that it holds data. It then pulses a read request for one clock and captures the returned word into a holding register. It presents that word on an output bus and raises a data-ready level that can serve as an interrupt source. The controller then does nothing further until the host signals that it has consumed the packet.

The controller's state and all of its outputs change on the falling clock edge. The FIFO, which works on the rising edge, therefore always samples settled levels. The FIFO's registered read data is taken on the falling edge after the read request. The host acknowledge may arrive from any timing domain. It passes through a two-flop synchronizer and an edge detector, so an acknowledge that is held high consumes only one packet.

Top module: `pkt_handoff`

## Requirements
- R1: While synchronous reset is high at a falling edge, the controller returns to idle with `fifo_rd` low, `pkt_ready` low and `pkt_data` all zeros.
- R2: When idle and `fifo_empty` is high, the controller stays idle and never raises `fifo_rd`. No read reaches an empty FIFO.
- R3: When a falling edge finds the controller idle with `fifo_empty` low, `fifo_rd` goes high on that edge and low again on the next falling edge, so it is high for exactly one clock.
- R4: `fifo_rd` is never high while `pkt_ready` is high.
- R5: On the falling edge after the one that raised `fifo_rd`, `fifo_rdata` is loaded into `pkt_data` and `pkt_ready` goes high. Packets appear in the order they were written to the FIFO.
- R6: While `pkt_ready` stays high, `pkt_data` does not change.
- R7: `pkt_ready` stays high until the acknowledge arrives. A rise of `host_ack` that is set up before a falling edge E clears `pkt_ready` on the second falling edge after E.
- R8: A `host_ack` that is held high consumes one packet only. Any later packet stays presented until `host_ack` goes low and then rises again.
- R9: After `pkt_ready` falls, the controller is idle. If the FIFO is not empty, `fifo_rd` rises on the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the controller acts on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_rdata | input | DATA_W | FIFO registered read data |
| fifo_rd | output | 1 | One-clock read request to the FIFO |
| pkt_data | output | DATA_W | Packet presented to the host |
| pkt_ready | output | 1 | Packet-waiting level, usable as an interrupt |
| host_ack | input | 1 | Host consumed-packet acknowledge, may be asynchronous |

## Verification
The bench drives its inputs and samples the outputs 1 ns after each rising edge. Every result that lands on a falling edge is therefore read half a cycle later. After an empty FIFO becomes non-empty, the read request is checked one sample later and the presented packet two samples later. After the acknowledge rises, `pkt_ready` is checked as still high two samples later and as low three samples later. The next read request is due at the fourth sample and the next packet at the fifth. A monitor checks every sample for single-clock reads, for reads during a pending packet and for a stable bus. It also checks each new packet against the bench FIFO model, which is mixed with random pushes and random acknowledge pulses.

// File: rtl/pkt_handoff.sv
module pkt_handoff #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  output logic [DATA_W-1:0] pkt_data,
  output logic              pkt_ready,
  input  logic              host_ack
);

  typedef enum logic [1:0] {S_IDLE, S_POP, S_HOLD} st_t;

  st_t  st;
  logic ack_s1, ack_s2, ack_d;
  logic ack_rise;

  always_ff @(negedge clk) begin
    if (rst) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      ack_d  <= 1'b0;
    end else begin
      ack_s1 <= host_ack;
      ack_s2 <= ack_s1;
      ack_d  <= ack_s2;
    end
  end

  assign ack_rise = ack_s2 & ~ack_d;

  always_ff @(negedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      fifo_rd   <= 1'b0;
      pkt_ready <= 1'b0;
      pkt_data  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (!fifo_empty) begin
            fifo_rd <= 1'b1;
            st      <= S_POP;
          end
        end
        S_POP: begin
          fifo_rd   <= 1'b0;
          pkt_data  <= fifo_rdata;
          pkt_ready <= 1'b1;
          st        <= S_HOLD;
        end
        S_HOLD: begin
          if (ack_rise) begin
            pkt_ready <= 1'b0;
            st        <= S_IDLE;
          end
        end
        default: begin
          fifo_rd   <= 1'b0;
          pkt_ready <= 1'b0;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  AST_RESET_CLEAR: assert property (@(negedge clk)
    $past(rst) |-> (!fifo_rd && !pkt_ready && pkt_data == '0)); // R1

  AST_NO_EMPTY_READ: assert property (@(negedge clk) disable iff (rst)
    $rose(fifo_rd) |-> $past(!fifo_empty)); // R2

  AST_READ_ONE_CYCLE: assert property (@(negedge clk) disable iff (rst)
    fifo_rd |=> !fifo_rd); // R3

  AST_NO_READ_PENDING: assert property (@(negedge clk) disable iff (rst)
    pkt_ready |-> !fifo_rd); // R4

  AST_PRESENT_CAPTURE: assert property (@(negedge clk) disable iff (rst)
    $rose(pkt_ready) |-> ($past(fifo_rd) && pkt_data == $past(fifo_rdata))); // R5

  AST_DATA_STABLE: assert property (@(negedge clk) disable iff (rst)
    (pkt_ready && $past(pkt_ready)) |-> $stable(pkt_data)); // R6

  AST_READY_UNTIL_ACK: assert property (@(negedge clk) disable iff (rst)
    $fell(pkt_ready) |-> $past(ack_rise)); // R7

endmodule

// File: tb/test_pkt_handoff.sv
module test_pkt_handoff;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         host_ack = 1'b0;
  logic         fifo_rd;
  logic         pkt_ready;
  logic [W-1:0] pkt_data;
  logic [W-1:0] rdata = '0;
  logic         empty;

  logic [W-1:0] mem [512];
  int head = 0, tail = 0, ridx = 0;
  int checks = 0, errors = 0;
  bit mon_on = 0, finished = 0, prod_done = 0;

  always #10 clk = ~clk;

  assign empty = (head == tail);

  pkt_handoff #(.DATA_W(W)) i_pkt_handoff (
    .clk(clk), .rst(rst), .fifo_empty(empty), .fifo_rdata(rdata),
    .fifo_rd(fifo_rd), .pkt_data(pkt_data), .pkt_ready(pkt_ready),
    .host_ack(host_ack)
  );

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic push(logic [W-1:0] v);
    tick(1);
    mem[tail % 512] = v;
    tail = tail + 1;
  endtask

  function automatic logic [W-1:0] exp_word(int idx);
    return mem[idx % 512];
  endfunction

  always @(posedge clk) begin
    if (fifo_rd) begin
      checks++;
      if (head == tail) begin
        errors++;
        $display("FAIL R2 read of empty FIFO actual=1 expected=0 t=%0t", $time);
      end else begin
        rdata <= mem[head % 512];
        head  <= head + 1;
      end
    end
  end

  logic         p_rd = 0, p_ready = 0;
  logic [W-1:0] p_data = '0;
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      chk(!(fifo_rd && p_rd), "R3 read longer than one clock", W'(fifo_rd), '0);
      chk(!(fifo_rd && pkt_ready), "R4 read while pending", W'(fifo_rd), '0);
      if (pkt_ready && p_ready)
        chk(pkt_data == p_data, "R6 data changed while ready", pkt_data, p_data);
      if (pkt_ready && !p_ready) begin
        chk(pkt_data == exp_word(ridx), "R5 packet order/value", pkt_data, exp_word(ridx));
        ridx++;
      end
    end
    p_rd = fifo_rd;
    p_ready = pkt_ready;
    p_data = pkt_data;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", ridx, tail);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2011));
    tick(3);
    chk(fifo_rd == 0, "R1 reset read", W'(fifo_rd), '0);
    chk(pkt_ready == 0, "R1 reset ready", W'(pkt_ready), '0);
    chk(pkt_data == '0, "R1 reset data", pkt_data, '0);
    rst = 1'b0;
    mon_on = 1;

    tick(10);
    chk(fifo_rd == 0 && pkt_ready == 0, "R2 idle on empty", W'({fifo_rd, pkt_ready}), '0);

    push(32'hA5A5_0001);
    tick(1);
    chk(fifo_rd == 1, "R3 read raised", W'(fifo_rd), 1);
    chk(pkt_ready == 0, "R5 ready not yet", W'(pkt_ready), 0);
    tick(1);
    chk(fifo_rd == 0, "R3 read dropped", W'(fifo_rd), 0);
    chk(pkt_ready == 1, "R5 ready raised", W'(pkt_ready), 1);
    chk(pkt_data == 32'hA5A5_0001, "R5 data presented", pkt_data, 32'hA5A5_0001);

    tick(10);
    chk(pkt_ready == 1, "R7 ready held without ack", W'(pkt_ready), 1);
    push(32'h0000_BEEF);
    push(32'h1234_5678);
    tick(5);
    chk(fifo_rd == 0, "R4 no read while pending", W'(fifo_rd), 0);
    chk(pkt_data == 32'hA5A5_0001, "R6 data held", pkt_data, 32'hA5A5_0001);

    host_ack = 1'b1;
    tick(2);
    chk(pkt_ready == 1, "R7 ready before sync delay", W'(pkt_ready), 1);
    tick(1);
    chk(pkt_ready == 0, "R7 ready cleared", W'(pkt_ready), 0);
    chk(fifo_rd == 0, "R9 no read yet", W'(fifo_rd), 0);
    tick(1);
    chk(fifo_rd == 1, "R9 next read", W'(fifo_rd), 1);
    tick(1);
    chk(pkt_ready == 1 && pkt_data == 32'h0000_BEEF, "R9 next packet", pkt_data, 32'h0000_BEEF);

    tick(30);
    chk(pkt_ready == 1, "R8 held ack consumed one", W'(pkt_ready), 1);
    chk(pkt_data == 32'h0000_BEEF, "R8 second packet kept", pkt_data, 32'h0000_BEEF);
    host_ack = 1'b0;
    tick(3);
    host_ack = 1'b1;
    tick(5);
    chk(pkt_ready == 1 && pkt_data == 32'h1234_5678, "R8 fresh edge consumes", pkt_data, 32'h1234_5678);
    host_ack = 1'b0;
    tick(3);
    host_ack = 1'b1;
    tick(4);
    host_ack = 1'b0;
    chk(pkt_ready == 0, "R7 last packet consumed", W'(pkt_ready), 0);
    tick(5);

    fork
      begin
        for (int i = 0; i < 300; i++) begin
          tick(1);
          if ($urandom % 4 == 0) begin
            mem[tail % 512] = $urandom;
            tail = tail + 1;
          end
        end
        prod_done = 1;
      end
      begin
        while (!(prod_done && ridx == tail && !pkt_ready)) begin
          tick(1);
          if (pkt_ready) begin
            tick($urandom % 5);
            host_ack = 1'b1;
            tick(1 + $urandom % 5);
            host_ack = 1'b0;
            tick(3);
          end
        end
      end
    join

    tick(5);
    chk(ridx == tail, "R5 all packets delivered", W'(ridx), W'(tail));
    chk(empty == 1, "R2 FIFO drained", W'(empty), 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule